// File: doc/BRIEF.md
# Serial LSB-First Binary-Field Multiplier

This block multiplies two elements of GF(2^m) held in polynomial basis. The result is Z = A·B reduced modulo a fixed irreducible polynomial F, and F is chosen when the block is instantiated. The multiplier takes one coefficient of B per clock cycle, starting from the lowest. In every cycle it also multiplies a working copy of A by x and reduces that copy modulo F. An accumulator adds in the current A copy whenever the current B bit is one. A product takes one load cycle plus m accumulation cycles.

The caller sets the operands and pulses `start` while the block is idle or finished. The operands must stay stable through the cycle that follows the start pulse, because the block captures them at the end of that cycle. When `done` goes high, `z` holds the product. Both stay unchanged until the next start is accepted. A start that arrives during a load or an accumulation is dropped.

Top module: `gf_lsb_mult`

## Requirements
- R1: After a cycle with `rst` high, `done` is 0 and `z` is all zeros.
- R2: With the default parameters (M = 8, F = x^8+x^4+x^3+x+1, given as 9'h11B), `z` equals the carry-less product of `a_in` and `b_in` reduced modulo F. This holds for zero, one, all-ones and arbitrary operands.
- R3: With M = 5 and F = x^5+x^2+1 (6'h25), the same product rule holds.
- R4: Suppose `start` is sampled high at clock edge e0. Then `done` first reads 1 after edge e0+M+1, and it reads 0 after every edge before that.
- R5: While `done` is 1 and `start` stays low, `done` stays 1 and `z` does not change.
- R6: A `start` pulse that arrives during a load or an accumulation has no effect. The running product finishes at its normal time with the correct value, and `done` then stays high.
- R7: When `start` is accepted while `done` is 1, `done` is 0 after the next edge and `z` is all zeros after the edge that follows it.
- R8: The operands are captured at edge e0+1. Any change to `a_in` or `b_in` after that edge does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a product; accepted only when idle or finished |
| a_in | input | M | Multiplicand A |
| b_in | input | M | Multiplier B, consumed lowest bit first |
| z | output | M | Product register |
| done | output | 1 | Product valid; held until next accepted start |

## Verification
Two events can land in the same cycle: the final accumulation step, which raises `done`, and a new `start` request. The bench places a start pulse so that it is sampled on the exact edge of the last step. It then checks that `done` rises on time, that `done` stays high, and that `z` still equals the reference product for several cycles afterwards. Back-to-back products are checked in a separate way. A start is issued on the first cycle `done` is seen. The bench then checks that `done` falls after one edge and that `z` clears after the next.

// File: rtl/gf_lsb_pkg.sv
package gf_lsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_HOLD = 2'd3
  } gf_state_t;
endpackage

// File: rtl/gf_lsb_xtime.sv
// Multiply by x and reduce modulo F (leading term of F implicit).
module gf_lsb_xtime #(
  parameter int M = 8,
  parameter logic [M:0] FPOLY = 9'h11B
) (
  input  logic [M-1:0] a_cur,
  output logic [M-1:0] a_nxt
);
  logic top;
  assign top = a_cur[M-1];

  assign a_nxt[0] = top & FPOLY[0];
  for (genvar i = 1; i < M; i++) begin : g_xt
    assign a_nxt[i] = a_cur[i-1] ^ (top & FPOLY[i]);
  end
endmodule

// File: rtl/gf_lsb_acc.sv
// One accumulation step: add A into C when the current B bit is set.
module gf_lsb_acc #(
  parameter int M = 8
) (
  input  logic [M-1:0] c_cur,
  input  logic [M-1:0] a_cur,
  input  logic         b_bit,
  output logic [M-1:0] c_nxt
);
  for (genvar i = 0; i < M; i++) begin : g_acc
    assign c_nxt[i] = c_cur[i] ^ (b_bit & a_cur[i]);
  end
endmodule

// File: rtl/gf_lsb_ctrl.sv
module gf_lsb_ctrl
  import gf_lsb_pkg::*;
#(
  parameter int M = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic done
);
  localparam int CW = $clog2(M) + 1;
  localparam logic [CW-1:0] LAST = CW'(M - 1);

  gf_state_t state;
  logic [CW-1:0] cnt;

  assign load = (state == ST_LOAD);
  assign step = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_LOAD;
        ST_LOAD: begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          if (cnt == LAST) begin
            state <= ST_HOLD;
            done  <= 1'b1;
          end
          cnt <= cnt + 1'b1;
        end
        ST_HOLD: if (start) begin
          state <= ST_LOAD;
          done  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_LOAD || state == ST_RUN) && start) |=> (state != ST_LOAD));

  // R4
  load_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |=> (state == ST_RUN && cnt == '0));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (cnt <= LAST));

  // R7
  restart_drop_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && start) |=> (state == ST_LOAD && !done));
endmodule

// File: rtl/gf_lsb_mult.sv
module gf_lsb_mult #(
  parameter int M = 8,
  parameter logic [M:0] FPOLY = 9'h11B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic [M-1:0] z,
  output logic         done
);
  logic         load, step;
  logic [M-1:0] a_q, b_q, c_q;
  logic [M-1:0] a_nxt, c_nxt;

  gf_lsb_ctrl #(.M(M)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .done(done)
  );

  gf_lsb_xtime #(.M(M), .FPOLY(FPOLY)) u_xtime (
    .a_cur(a_q), .a_nxt(a_nxt)
  );

  gf_lsb_acc #(.M(M)) u_acc (
    .c_cur(c_q), .a_cur(a_q), .b_bit(b_q[0]), .c_nxt(c_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (load) begin
      a_q <= a_in;
      b_q <= b_in;
      c_q <= '0;
    end else if (step) begin
      a_q <= a_nxt;
      b_q <= b_q >> 1;
      c_q <= c_nxt;
    end
  end

  assign z = c_q;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && z == '0));

  // R5
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(z)));

  // R7
  load_clears_acc_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (z == '0));
endmodule

// File: tb/gf_lsb_mult_tb.sv
module gf_lsb_mult_tb;
  localparam int CLK_PERIOD = 10;
  localparam int M8 = 8;
  localparam int M5 = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, start5 = 1'b0;
  logic [M8-1:0] a8 = '0, b8 = '0, z8;
  logic [M5-1:0] a5 = '0, b5 = '0, z5;
  logic done8, done5;

  int checks = 0;
  int fails = 0;
  longint cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf_lsb_mult #(.M(M8), .FPOLY(9'h11B)) u_dut (
    .clk(clk), .rst(rst), .start(start), .a_in(a8), .b_in(b8),
    .z(z8), .done(done8)
  );

  gf_lsb_mult #(.M(M5), .FPOLY(6'h25)) u_dut_w5 (
    .clk(clk), .rst(rst), .start(start5), .a_in(a5), .b_in(b5),
    .z(z5), .done(done5)
  );

  function automatic logic [15:0] gf_ref(input logic [15:0] a, input logic [15:0] b,
                                         input int m, input logic [16:0] poly);
    logic [31:0] p;
    p = '0;
    for (int i = 0; i < m; i++) if (b[i]) p ^= (32'(a) << i);
    for (int i = 2*m-2; i >= m; i--) if (p[i]) p ^= (32'(poly) << (i-m));
    return p[15:0];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  // One product on the 8-bit instance. scramble: alter operands after capture (R8).
  // late_start: pulse start on the final step edge (R6).
  task automatic op8(input logic [7:0] a, input logic [7:0] b,
                     input bit scramble, input bit late_start);
    logic [7:0] exp;
    int n;
    exp = gf_ref({8'h0, a}, {8'h0, b}, M8, 17'h11B)[7:0];
    a8 = a; b8 = b; start = 1'b1;
    @(negedge clk);             // after e0
    start = 1'b0;
    chk("R4 done low after start", {15'h0, done8}, 16'h0);
    n = 0;
    while (!done8 && n < M8 + 10) begin
      @(negedge clk);
      n++;
      if (n == 1 && scramble) begin a8 = ~a; b8 = b ^ 8'h5A; end
      if (n == 1) chk("R7 z cleared by load", {8'h0, z8}, 16'h0);
      if (n == M8 && late_start) start = 1'b1;
      if (n == M8 + 1) start = 1'b0;
    end
    start = 1'b0;
    chk("R4 latency", 16'(n), 16'(M8 + 1));
    chk(scramble ? "R8 operand capture" : "R2 product", {8'h0, z8}, {8'h0, exp});
    if (late_start) begin
      repeat (3) @(negedge clk);
      chk("R6 done kept", {15'h0, done8}, 16'h1);
      chk("R6 z kept", {8'h0, z8}, {8'h0, exp});
    end
  endtask

  task automatic op5(input logic [4:0] a, input logic [4:0] b);
    int n;
    a5 = a; b5 = b; start5 = 1'b1;
    @(negedge clk);
    start5 = 1'b0;
    n = 0;
    while (!done5 && n < M5 + 10) begin @(negedge clk); n++; end
    chk("R3 latency", 16'(n), 16'(M5 + 1));
    chk("R3 product", {11'h0, z5}, gf_ref({11'h0, a}, {11'h0, b}, M5, 17'h25));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 done after reset", {15'h0, done8}, 16'h0);
    chk("R1 z after reset", {8'h0, z8}, 16'h0);

    // R2 directed corners
    op8(8'h00, 8'hA5, 0, 0);
    op8(8'hC3, 8'h00, 0, 0);
    op8(8'h01, 8'h7E, 0, 0);
    op8(8'h9D, 8'h01, 0, 0);
    op8(8'hFF, 8'hFF, 0, 0);
    op8(8'h57, 8'h83, 0, 0);
    op8(8'h80, 8'h80, 0, 0);

    // R5 hold while idle in finished state
    begin
      logic [7:0] zh;
      zh = z8;
      repeat (5) @(negedge clk);
      chk("R5 done held", {15'h0, done8}, 16'h1);
      chk("R5 z held", {8'h0, z8}, {8'h0, zh});
    end

    // R6 start on the final step edge
    op8(8'h3B, 8'hE1, 0, 1);
    // R8 operands changed after capture
    op8(8'hB4, 8'h6D, 1, 0);

    // R7 back-to-back random products, restart on first done cycle
    for (int k = 0; k < 40; k++) begin
      op8(8'($urandom), 8'($urandom), 0, 0);
    end

    // R3 second field size
    op5(5'h00, 5'h1F);
    op5(5'h01, 5'h13);
    op5(5'h1F, 5'h1F);
    for (int k = 0; k < 20; k++) op5(5'($urandom), 5'($urandom));

    // R1 reset mid-operation
    a8 = 8'hF0; b8 = 8'h0F; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 done after mid reset", {15'h0, done8}, 16'h0);
    chk("R1 z after mid reset", {8'h0, z8}, 16'h0);
    repeat (M8 + 3) @(negedge clk);
    chk("R1 stays idle", {15'h0, done8}, 16'h0);

    finish_run();
  end
endmodule